// File: doc/BRIEF.md
# Two-Acknowledge Priority Interrupt Controller

This block gathers eight level-sensitive hardware request lines and raises a single interrupt output toward a processor or any agent that can issue acknowledge pulses. A mask register can hide any line. Priority is fixed: line 0 wins over every other line and line 7 loses to all of them. A line can interrupt only if it is unmasked and ranks strictly above every line currently marked as in service.

Each interrupt is served by two one-cycle pulses on `inta`. The first pulse picks the winning line, marks it in service and drops the interrupt output. The second pulse makes the controller present an 8-bit vector, formed from a programmable 5-bit base and the 3-bit line number, for exactly one cycle. The output has no back-pressure, because the vector appears only when the acknowledging agent asks for it with the second pulse. If no eligible request is still asserted at the first pulse, the controller answers with the vector of line 7 as a spurious interrupt and marks nothing in service. Software ends service with an end-of-interrupt command sent through a small write port. This command is separate from the acknowledge pulses.

Top module: `pic_2ack`

## Requirements
- R1: While no handshake is open, `int_out` is high in the same cycle in which some unmasked request line ranks above every in-service line.
- R2: After `int_out` rises, the controller changes no state until a first `inta` pulse arrives, however long that takes. Likewise, between the two pulses it waits for the second pulse indefinitely.
- R3: A first `inta` pulse marks in service the lowest-numbered unmasked request line that is asserted in that cycle and that outranks every in-service line.
- R4: The cycle after a second `inta` pulse, `vec_valid` is high for exactly one cycle, with `vec_data` = {base[4:0], line[2:0]}.
- R5: If no eligible line is asserted at the first pulse, the vector reports line 7 and no in-service bit is set.
- R6: A request whose line number is equal to or greater than that of the lowest-numbered in-service line does not raise `int_out`.
- R7: `int_out` is low from the cycle after the first pulse until the second pulse has been taken.
- R8: A write to address 2 with bit 7 = 0 (non-specific end of interrupt) clears the lowest-numbered in-service bit.
- R9: A write to address 2 with bit 7 = 1 (specific end of interrupt) clears the in-service bit named by bits 2:0.
- R10: A write to address 0 loads the mask, where bit i = 1 blocks line i. A write to address 1 loads the base from bits 4:0. A write to address 3 has no effect. Reset sets the mask to all ones, the base to 0 and the in-service set to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 8 | Level request lines, bit 0 highest priority |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | Write address: 0 mask, 1 base, 2 end of interrupt |
| cfg_wdata | input | 8 | Write data |
| int_out | output | 1 | Interrupt toward the acknowledging agent |
| inta | input | 1 | Acknowledge pulse, one cycle wide |
| vec_valid | output | 1 | Vector present, one-cycle pulse |
| vec_data | output | 8 | Vector value |

## Verification
The hardest case to reach from the ports is the spurious answer. A request must raise `int_out` and then vanish before the first pulse, and a later check must show that line 7 was not marked in service. The stimulus first raises line 2 and then drops it, and only after that does it issue both pulses. It then clears the other in-service line and raises line 7. A rising `int_out` can only happen if the spurious answer left line 7 unmarked. In-service state is otherwise invisible, so it is also inferred through which lines can still raise `int_out` after each end-of-interrupt command.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic {HS_IDLE = 1'b0, HS_WAIT2 = 1'b1} hs_state_e;

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_BASE = 2'd1;
  localparam logic [1:0] ADDR_EOI  = 2'd2;

  localparam int EOI_SPECIFIC_BIT = 7;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int N      = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(N),
  parameter int BASE_W = DATA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              isr_any,
  input  logic [IDX_W-1:0]  isr_top,
  output logic [N-1:0]      mask_q,
  output logic [BASE_W-1:0] base_q,
  output logic [N-1:0]      isr_q
);
  logic [N-1:0] clr_vec;
  logic [N-1:0] set_vec;
  logic         eoi_we;

  assign eoi_we = cfg_we && (cfg_addr == ADDR_EOI);

  always_comb begin
    clr_vec = '0;
    if (eoi_we) begin
      if (cfg_wdata[EOI_SPECIFIC_BIT])
        clr_vec[cfg_wdata[IDX_W-1:0]] = 1'b1;
      else if (isr_any)
        clr_vec[isr_top] = 1'b1;
    end
    set_vec = '0;
    if (set_en) set_vec[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      base_q <= '0;
      isr_q  <= '0;
    end else begin
      if (cfg_we && cfg_addr == ADDR_MASK) mask_q <= cfg_wdata[N-1:0];
      if (cfg_we && cfg_addr == ADDR_BASE) base_q <= cfg_wdata[BASE_W-1:0];
      isr_q <= (isr_q & ~clr_vec) | set_vec;
    end
  end

  // R3: one acknowledge marks at most one line per cycle
  assert_one_isr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_q & ~$past(isr_q)));
endmodule

// File: rtl/pic_hs.sv
module pic_hs
  import pic_pkg::*;
#(
  parameter int N      = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(N),
  parameter int BASE_W = DATA_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inta,
  input  logic              elig,
  input  logic [IDX_W-1:0]  cand_idx,
  input  logic [BASE_W-1:0] base,
  output logic              in_wait,
  output logic              set_en,
  output logic [IDX_W-1:0]  set_idx,
  output logic              vec_valid,
  output logic [DATA_W-1:0] vec_data
);
  localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(N - 1);

  hs_state_e        state_q;
  logic [IDX_W-1:0] line_q;
  logic             ack1;

  assign in_wait = (state_q == HS_WAIT2);
  assign ack1    = inta && !in_wait;
  assign set_en  = ack1 && elig;
  assign set_idx = cand_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= HS_IDLE;
      line_q    <= '0;
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      vec_valid <= 1'b0;
      if (ack1) begin
        state_q <= HS_WAIT2;
        line_q  <= elig ? cand_idx : SPUR_IDX;
      end else if (inta && in_wait) begin
        state_q   <= HS_IDLE;
        vec_valid <= 1'b1;
        vec_data  <= {base, line_q};
      end
    end
  end

  // R2: the handshake waits for its second pulse without limit
  assert_wait_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !inta) |=> in_wait);
  // R4: the vector is a single-cycle pulse
  assert_vec_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
endmodule

// File: rtl/pic_2ack.sv
module pic_2ack
  import pic_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LINES-1:0] irq_req,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              int_out,
  input  logic              inta,
  output logic              vec_valid,
  output logic [DATA_W-1:0] vec_data
);
  localparam int IDX_W  = $clog2(N_LINES);
  localparam int BASE_W = DATA_W - IDX_W;

  logic [N_LINES-1:0] mask_q, isr_q, pending;
  logic [BASE_W-1:0]  base_q;
  logic               cand_any, isr_any, elig, in_wait, set_en;
  logic [IDX_W-1:0]   cand_idx, isr_top, set_idx;

  assign pending = irq_req & ~mask_q;

  pic_prio #(.N(N_LINES), .IDX_W(IDX_W)) u_req_prio (
    .req(pending), .any(cand_any), .idx(cand_idx));

  pic_prio #(.N(N_LINES), .IDX_W(IDX_W)) u_isr_prio (
    .req(isr_q), .any(isr_any), .idx(isr_top));

  assign elig    = cand_any && (!isr_any || (cand_idx < isr_top));
  assign int_out = elig && !in_wait;

  pic_regs #(.N(N_LINES), .DATA_W(DATA_W), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .set_en(set_en), .set_idx(set_idx),
    .isr_any(isr_any), .isr_top(isr_top),
    .mask_q(mask_q), .base_q(base_q), .isr_q(isr_q));

  pic_hs #(.N(N_LINES), .DATA_W(DATA_W), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_hs (
    .clk(clk), .rst_n(rst_n), .inta(inta), .elig(elig), .cand_idx(cand_idx),
    .base(base_q), .in_wait(in_wait), .set_en(set_en), .set_idx(set_idx),
    .vec_valid(vec_valid), .vec_data(vec_data));

  // R7: no interrupt while the handshake is half done
  assert_int_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !int_out);
  // R5: a spurious first pulse leaves the in-service set untouched
  assert_spur_no_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !in_wait && !elig && !cfg_we) |=> $stable(isr_q));
endmodule

// File: tb/test_pic_2ack.sv
module test_pic_2ack;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       inta = 1'b0;
  logic       int_out, vec_valid;
  logic [7:0] vec_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  pic_2ack i_pic_2ack (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .int_out(int_out),
    .inta(inta), .vec_valid(vec_valid), .vec_data(vec_data));

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_req = v; #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0; #1;
  endtask

  task automatic pulse;
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0; #1;
  endtask

  // driver: first pulse, then second pulse with the expected vector queued
  task automatic serve(input logic [7:0] exp, input string req);
    pulse();
    chk({7'd0, int_out}, 8'd0, "R7");
    exp_q.push_back(exp);
    tag_q.push_back(req);
    pulse();
  endtask

  // monitor: scoreboard compare on every vector pulse
  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R4: actual %h expected none", vec_data);
      end else begin
        chk(vec_data, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    irq_req = 8'h08;
    repeat (3) @(negedge clk);
    #1;
    chk({7'd0, int_out}, 8'd0, "R10 reset mask");
    chk({7'd0, vec_valid}, 8'd0, "R4 reset");
    rst_n = 1'b1;
    irq_req = '0;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h10);
    set_irq(8'h08);
    chk({7'd0, int_out}, 8'd1, "R1");
    repeat (6) @(negedge clk);
    #1;
    chk({7'd0, int_out}, 8'd1, "R2 waits");
    pulse();
    repeat (5) @(negedge clk);
    #1;
    chk({7'd0, int_out}, 8'd0, "R7 hold");
    exp_q.push_back(8'h83); tag_q.push_back("R4 line3");
    pulse();
    set_irq(8'h00);
    // in service {3}
    set_irq(8'h08);
    chk({7'd0, int_out}, 8'd0, "R6 equal");
    set_irq(8'h20);
    chk({7'd0, int_out}, 8'd0, "R6 lower");
    set_irq(8'h22);
    chk({7'd0, int_out}, 8'd1, "R6 higher");
    serve(8'h81, "R3 line1");
    set_irq(8'h00);
    // in service {1,3}
    wr(2'd2, 8'h00);
    set_irq(8'h04);
    chk({7'd0, int_out}, 8'd1, "R8 cleared 1");
    set_irq(8'h08);
    chk({7'd0, int_out}, 8'd0, "R8 kept 3");
    set_irq(8'h00);
    wr(2'd2, 8'h83);
    set_irq(8'h68);
    chk({7'd0, int_out}, 8'd1, "R9");
    serve(8'h83, "R3 pick3");
    set_irq(8'h00);
    // spurious: request disappears before the first pulse
    set_irq(8'h04);
    chk({7'd0, int_out}, 8'd1, "R1 line2");
    set_irq(8'h00);
    chk({7'd0, int_out}, 8'd0, "R1 dropped");
    serve(8'h87, "R5 spurious");
    wr(2'd2, 8'h83);
    set_irq(8'h80);
    chk({7'd0, int_out}, 8'd1, "R5 no isr7");
    serve(8'h87, "R4 line7");
    set_irq(8'h00);
    wr(2'd2, 8'h00);
    // mask and base
    wr(2'd0, 8'h01);
    set_irq(8'h01);
    chk({7'd0, int_out}, 8'd0, "R10 masked");
    set_irq(8'h03);
    chk({7'd0, int_out}, 8'd1, "R10 unmasked");
    wr(2'd1, 8'h03);
    serve(8'h19, "R4 base");
    set_irq(8'h00);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'hFF);
    set_irq(8'h02);
    chk({7'd0, int_out}, 8'd1, "R10 addr3 ignored");
    set_irq(8'h00);
    repeat (3) @(negedge clk);
    chk(8'(exp_q.size()), 8'd0, "R4 all vectors seen");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule